// File: doc/BRIEF.md
# Processor Reset State Initializer

This block sets up the architectural state a processor core starts from when it leaves reset into 64-bit execution. When a reset request arrives, it works out the highest implemented exception level and takes the core's entry level from it. It puts every processor state flag into its fixed reset value. It then loads the program counter from the reset vector base register that belongs to the chosen level.

The chosen vector is also checked. Its two lowest bits must be zero, and it must not set any bit at or above the configured physical address width. If either rule is broken, an error flag is raised next to the loaded program counter. Warm and cold requests produce the same state. The cold indication is registered and passed on, so that logic further downstream can decide how much more to clear. Exception return registers, general-purpose registers, SIMD registers and debug registers are not touched here.

Top module: `rst_state_init`

## Requirements
- R1: On a sampled request, `el_o` becomes 3 when level 3 is present; otherwise it becomes 2 when level 2 is present; otherwise it becomes 1.
- R2: On a sampled request, `width32_o` is cleared to 0 (64-bit execution) and `sp_sel_o` is set to 1.
- R3: On a sampled request, `mask_o` becomes 4'b1111. Bit 3 is the debug mask, bit 2 the SError mask, bit 1 the IRQ mask and bit 0 the FIQ mask.
- R4: On a sampled request, `step_o`, `dit_o` and `illegal_o` are all cleared to 0.
- R5: On a sampled request, `pc_o` is loaded with the reset vector input of the chosen entry level, even when that vector is in error.
- R6: `align_err_o` is set when bit 1 or bit 0 of the loaded vector is 1.
- R7: `align_err_o` is set when any vector bit at an index greater than or equal to `pa_bits_i` is 1. A `pa_bits_i` of 64 or more applies no range limit.
- R8: All outputs are registered and take their new values at the clock edge that samples `req_i` high. `done_o` is high for exactly the cycle after each sampled request.
- R9: `cold_o` loads `cold_i` on each sampled request. Every other output is identical for cold and warm requests.
- R10: While `rst_n` is low, every output is 0. Between requests, the state outputs hold their values whatever the configuration inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| req_i | input | 1 | Reset-state request, sampled each clock |
| cold_i | input | 1 | 1 = cold request, 0 = warm request |
| has_el3_i | input | 1 | Level 3 is implemented |
| has_el2_i | input | 1 | Level 2 is implemented |
| vbar1_i | input | VEC_W | Reset vector base for level 1 |
| vbar2_i | input | VEC_W | Reset vector base for level 2 |
| vbar3_i | input | VEC_W | Reset vector base for level 3 |
| pa_bits_i | input | PAW_W | Maximum physical address width in bits |
| el_o | output | 2 | Entry exception level |
| width32_o | output | 1 | Register-width state bit (0 = 64-bit) |
| sp_sel_o | output | 1 | Stack pointer select |
| mask_o | output | 4 | Asynchronous masks {debug, SError, IRQ, FIQ} |
| step_o | output | 1 | Software-step bit |
| dit_o | output | 1 | Data-independent-timing bit |
| illegal_o | output | 1 | Illegal-execution bit |
| pc_o | output | VEC_W | Reset program counter |
| align_err_o | output | 1 | Vector misaligned or out of physical range |
| done_o | output | 1 | One-cycle pulse after a sampled request |
| cold_o | output | 1 | Registered cold indication |

## Verification
The sweep covers every combination of implemented levels. In each one, the two unselected vector registers hold values that differ from the selected one. A wrong priority or a wrong mux select would therefore show up as a wrong level or a wrong program counter. Vectors are placed exactly on the top legal bit and exactly on the first illegal bit for several address widths, including the full 64-bit width. An off-by-one range comparison would flag a legal vector or miss an illegal one, and a range mask that overflows at full width would flag everything. The bench also changes the configuration between requests and toggles the cold flag. A design that let outputs follow its inputs, or that treated cold and warm requests differently, would change outputs that should hold.

// File: rtl/rsi_pkg.sv
package rsi_pkg;

  typedef logic [1:0] el_t;

  localparam el_t LVL1 = 2'd1;
  localparam el_t LVL2 = 2'd2;
  localparam el_t LVL3 = 2'd3;

  typedef struct packed {
    el_t        el;
    logic       width32;
    logic       sp_sel;
    logic [3:0] mask;
    logic       step;
    logic       dit;
    logic       illegal;
  } pstate_t;

  // Highest implemented level wins.
  function automatic el_t pick_level(input logic h3, input logic h2);
    if (h3)      return LVL3;
    else if (h2) return LVL2;
    else         return LVL1;
  endfunction

  // Fixed field values applied on every request, warm or cold.
  function automatic pstate_t entry_state(input el_t lvl);
    pstate_t s;
    s.el      = lvl;
    s.width32 = 1'b0;
    s.sp_sel  = 1'b1;
    s.mask    = 4'b1111;
    s.step    = 1'b0;
    s.dit     = 1'b0;
    s.illegal = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/rsi_entry_sel.sv
module rsi_entry_sel
  import rsi_pkg::*;
#(
  parameter int VEC_W = 64
) (
  input  logic             has_el3,
  input  logic             has_el2,
  input  logic [VEC_W-1:0] vbar1,
  input  logic [VEC_W-1:0] vbar2,
  input  logic [VEC_W-1:0] vbar3,
  output el_t              lvl,
  output logic [VEC_W-1:0] vec
);

  always_comb begin
    lvl = pick_level(has_el3, has_el2);
    unique case (lvl)
      LVL3:    vec = vbar3;
      LVL2:    vec = vbar2;
      default: vec = vbar1;
    endcase
  end

endmodule

// File: rtl/rsi_vec_check.sv
module rsi_vec_check #(
  parameter int VEC_W = 64,
  parameter int PAW_W = $clog2(VEC_W + 1)
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [PAW_W-1:0] pa_bits,
  output logic             low_bad,
  output logic             high_bad
);

  logic [VEC_W-1:0] over;

  // Bit i is illegal when it is set and lies at or above the address width.
  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    assign over[i] = vec[i] && (PAW_W'(i) >= pa_bits);
  end

  assign low_bad  = |vec[1:0];
  assign high_bad = |over;

endmodule

// File: rtl/rsi_state_reg.sv
module rsi_state_reg
  import rsi_pkg::*;
#(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  pstate_t          nxt_state,
  input  logic [VEC_W-1:0] nxt_pc,
  input  logic             nxt_err,
  input  logic             nxt_cold,
  output pstate_t          state,
  output logic [VEC_W-1:0] pc,
  output logic             err,
  output logic             cold,
  output logic             done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
      pc    <= '0;
      err   <= 1'b0;
      cold  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        state <= nxt_state;
        pc    <= nxt_pc;
        err   <= nxt_err;
        cold  <= nxt_cold;
      end
    end
  end

endmodule

// File: rtl/rst_state_init.sv
module rst_state_init
  import rsi_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int PAW_W = $clog2(VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             cold_i,
  input  logic             has_el3_i,
  input  logic             has_el2_i,
  input  logic [VEC_W-1:0] vbar1_i,
  input  logic [VEC_W-1:0] vbar2_i,
  input  logic [VEC_W-1:0] vbar3_i,
  input  logic [PAW_W-1:0] pa_bits_i,
  output logic [1:0]       el_o,
  output logic             width32_o,
  output logic             sp_sel_o,
  output logic [3:0]       mask_o,
  output logic             step_o,
  output logic             dit_o,
  output logic             illegal_o,
  output logic [VEC_W-1:0] pc_o,
  output logic             align_err_o,
  output logic             done_o,
  output logic             cold_o
);

  // Named internal events, visible to the checker.
  el_t              sel_el;
  logic [VEC_W-1:0] sel_vec;
  logic             low_bad;
  logic             high_bad;
  logic             vec_err;
  pstate_t          nxt_state;
  pstate_t          cur_state;

  rsi_entry_sel #(.VEC_W(VEC_W)) u_sel (
    .has_el3 (has_el3_i),
    .has_el2 (has_el2_i),
    .vbar1   (vbar1_i),
    .vbar2   (vbar2_i),
    .vbar3   (vbar3_i),
    .lvl     (sel_el),
    .vec     (sel_vec)
  );

  rsi_vec_check #(.VEC_W(VEC_W), .PAW_W(PAW_W)) u_chk (
    .vec      (sel_vec),
    .pa_bits  (pa_bits_i),
    .low_bad  (low_bad),
    .high_bad (high_bad)
  );

  assign vec_err   = low_bad | high_bad;
  assign nxt_state = entry_state(sel_el);

  rsi_state_reg #(.VEC_W(VEC_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_i),
    .nxt_state (nxt_state),
    .nxt_pc    (sel_vec),
    .nxt_err   (vec_err),
    .nxt_cold  (cold_i),
    .state     (cur_state),
    .pc        (pc_o),
    .err       (align_err_o),
    .cold      (cold_o),
    .done      (done_o)
  );

  assign el_o      = cur_state.el;
  assign width32_o = cur_state.width32;
  assign sp_sel_o  = cur_state.sp_sel;
  assign mask_o    = cur_state.mask;
  assign step_o    = cur_state.step;
  assign dit_o     = cur_state.dit;
  assign illegal_o = cur_state.illegal;

endmodule

// File: rtl/rsi_checker.sv
module rsi_checker #(
  parameter int VEC_W = 64,
  parameter int PAW_W = $clog2(VEC_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             cold_i,
  input logic             has_el3_i,
  input logic             has_el2_i,
  input logic [VEC_W-1:0] vbar1_i,
  input logic [VEC_W-1:0] vbar2_i,
  input logic [VEC_W-1:0] vbar3_i,
  input logic [1:0]       el_o,
  input logic             width32_o,
  input logic             sp_sel_o,
  input logic [3:0]       mask_o,
  input logic             step_o,
  input logic             dit_o,
  input logic             illegal_o,
  input logic [VEC_W-1:0] pc_o,
  input logic             align_err_o,
  input logic             done_o,
  input logic             cold_o
);

  a_r1_entry_level: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> el_o == ($past(has_el3_i) ? 2'd3 : ($past(has_el2_i) ? 2'd2 : 2'd1)));

  a_r2_width_sp: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!width32_o && sp_sel_o));

  a_r3_masks_set: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> mask_o == 4'b1111);

  a_r4_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!step_o && !dit_o && !illegal_o));

  a_r5_vector_source: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> pc_o == ($past(has_el3_i) ? $past(vbar3_i) :
                        ($past(has_el2_i) ? $past(vbar2_i) : $past(vbar1_i))));

  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pc_o[1:0] != 2'b00) |-> align_err_o);

  a_r8_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !done_o);

  a_r9_cold_passed: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cold_o == $past(cold_i));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(pc_o) && $stable(el_o) && $stable(align_err_o)));

endmodule

bind rst_state_init rsi_checker #(.VEC_W(VEC_W), .PAW_W(PAW_W)) u_rsi_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .cold_i      (cold_i),
  .has_el3_i   (has_el3_i),
  .has_el2_i   (has_el2_i),
  .vbar1_i     (vbar1_i),
  .vbar2_i     (vbar2_i),
  .vbar3_i     (vbar3_i),
  .el_o        (el_o),
  .width32_o   (width32_o),
  .sp_sel_o    (sp_sel_o),
  .mask_o      (mask_o),
  .step_o      (step_o),
  .dit_o       (dit_o),
  .illegal_o   (illegal_o),
  .pc_o        (pc_o),
  .align_err_o (align_err_o),
  .done_o      (done_o),
  .cold_o      (cold_o)
);

// File: tb/test_rst_state_init.sv
`timescale 1ns/1ps
module test_rst_state_init;

  localparam int VW = 64;
  localparam int PW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic          cold_i = 1'b0;
  logic          has_el3_i = 1'b0;
  logic          has_el2_i = 1'b0;
  logic [VW-1:0] vbar1_i = '0;
  logic [VW-1:0] vbar2_i = '0;
  logic [VW-1:0] vbar3_i = '0;
  logic [PW-1:0] pa_bits_i = '0;
  logic [1:0]    el_o;
  logic          width32_o, sp_sel_o, step_o, dit_o, illegal_o;
  logic [3:0]    mask_o;
  logic [VW-1:0] pc_o;
  logic          align_err_o, done_o, cold_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rst_state_init i_rst_state_init (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cold_i(cold_i),
    .has_el3_i(has_el3_i), .has_el2_i(has_el2_i),
    .vbar1_i(vbar1_i), .vbar2_i(vbar2_i), .vbar3_i(vbar3_i),
    .pa_bits_i(pa_bits_i), .el_o(el_o), .width32_o(width32_o),
    .sp_sel_o(sp_sel_o), .mask_o(mask_o), .step_o(step_o), .dit_o(dit_o),
    .illegal_o(illegal_o), .pc_o(pc_o), .align_err_o(align_err_o),
    .done_o(done_o), .cold_o(cold_o)
  );

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input bit h3, input bit h2, input bit cold, input int pa,
                          input logic [VW-1:0] v);
    logic [1:0]    exp_el;
    logic [VW-1:0] decoy;
    bit            exp_err;
    logic [VW-1:0] hold_pc;
    exp_el = h3 ? 2'd3 : (h2 ? 2'd2 : 2'd1);
    decoy  = v ^ 64'h00F0_0000_0000_1234;
    exp_err = (v[1:0] != 2'b00) || (pa < 64 && (v >> pa) != 0);
    @(negedge clk);
    has_el3_i = h3; has_el2_i = h2; cold_i = cold; pa_bits_i = PW'(pa);
    vbar1_i = (exp_el == 2'd1) ? v : decoy;
    vbar2_i = (exp_el == 2'd2) ? v : decoy;
    vbar3_i = (exp_el == 2'd3) ? v : decoy;
    req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    chk("R1 entry level", VW'(el_o), VW'(exp_el));
    chk("R2 width/sp", VW'({width32_o, sp_sel_o}), VW'(2'b01));
    chk("R3 masks", VW'(mask_o), VW'(4'b1111));
    chk("R4 step/dit/illegal", VW'({step_o, dit_o, illegal_o}), '0);
    chk("R5 pc from chosen level", pc_o, v);
    if (v[1:0] != 2'b00) chk("R6 low-bit error", VW'(align_err_o), VW'(1'b1));
    else                 chk("R7 range error", VW'(align_err_o), VW'(exp_err));
    chk("R8 done pulse", VW'(done_o), VW'(1'b1));
    chk("R9 cold passthrough", VW'(cold_o), VW'(cold));
    hold_pc = pc_o;
    // Disturb configuration while idle: outputs must hold.
    vbar1_i = ~v; vbar2_i = ~v; vbar3_i = ~v; has_el3_i = ~h3; cold_i = ~cold;
    @(posedge clk);
    @(negedge clk);
    chk("R8 done one cycle", VW'(done_o), '0);
    chk("R10 pc holds", pc_o, hold_pc);
    chk("R10 el holds", VW'(el_o), VW'(exp_el));
    chk("R9 cold holds", VW'(cold_o), VW'(cold));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pas[5] = '{32, 40, 48, 52, 64};
    repeat (3) @(negedge clk);
    chk("R10 reset pc", pc_o, '0);
    chk("R10 reset el/flags", VW'({el_o, sp_sel_o, mask_o, done_o, align_err_o, cold_o}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", VW'({done_o, el_o}), '0);
    for (int h = 0; h < 4; h++) begin
      for (int c = 0; c < 2; c++) begin
        for (int p = 0; p < 5; p++) begin
          for (int k = 0; k < 6; k++) begin
            int pa;
            logic [VW-1:0] v;
            pa = pas[p];
            case (k)
              0: v = 64'h0000_0000_0000_1000;
              1: v = 64'h0000_0000_0000_1002;
              2: v = 64'h0000_0000_0000_1001;
              3: v = 64'd1 << (pa - 1);
              4: v = (pa < 64) ? (64'd1 << pa) : 64'h8000_0000_0000_0000;
              default: v = 64'hFFFF_FFFF_FFFF_FFFC;
            endcase
            run_case(h[1], h[0], c[0], pa, v);
          end
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule